// File: doc/BRIEF.md
# PLL Configuration Register Controller

This block holds the multiplier settings for five PLLs, known to software as PLL1, PLL2, PLL3, PLL4 and PLL6, which occupy slots 0 to 4. Each slot has two 32-bit words. Word 0 holds the integer factor, the mode bits, the modulation frequency, the modulation depth and a kick bit. Word 1 holds a fractional factor. Software writes these words into a staged copy. Setting the kick bit moves the staged multiplier and mode into an active copy. The kick also clears that PLL's lock flag and starts a lock-delay counter that stands in for the analog settle time. When the counter expires, the kick bit self-clears and the lock flag returns. The lock flags of all five PLLs appear at fixed, non-contiguous positions in one shared read-only status word.

The controller drives the effective integer multiplier and the effective fractional factor of each PLL from the active copy. Clock-tree logic downstream can use them to derive output rates, where rate = parent × (NI+1) × 2 + parent × NF / 2^24. The bus is word addressed. Slot s has word 0 at address 2s and word 1 at address 2s+1, and the status word sits at address 2·NUM_PLL (address 10 with the default of five slots). Reads are combinational from the address.

Top module: `pll_cfg_ctrl`

## Requirements
- R1: After reset, every lock flag reads 1. Every slot's word 0 and word 1 read 0, with the kick bit clear. Each mult_int_o field is 2 and each mult_frac_o field is 0.
- R2: A word 0 write whose bit 31 is 0 stores its fields into the staged copy. The fields are NI at bits 27:20, mode at 18:16, modulation frequency at 14:8 and depth at 6:0. They read back at those positions, and bits 30:28, 19, 15 and 7 read 0. The effective outputs do not change.
- R3: While a slot's kick is pending, writes to its NI field (word 0 bits 27:20) and its NF field (word 1 bits 24:0) are ignored. The staged values read back unchanged.
- R4: A word 0 write with bit 31 set, made while no kick is pending, takes the NI and mode from that same write. Together with the staged NF, it copies them into the active copy, and from the next cycle the slot's lock flag reads 0 and its kick bit reads 1.
- R5: With the accepting edge counted as cycle 0, the kick bit reads 1 and the lock flag reads 0 through cycle LOCK_CYCLES-1. Both change together at edge LOCK_CYCLES: the kick bit reads 0 and the lock flag reads 1.
- R6: mult_int_o for a slot equals (active NI + 1) × 2, as a 10-bit value.
- R7: mult_frac_o for a slot equals the active NF when active mode bit 18 (fractional mode) is set, and 0 otherwise.
- R8: The status word has lock flags at bit 8 (PLL1, slot 0), bit 9 (PLL2), bit 11 (PLL3), bit 13 (PLL4) and bit 15 (PLL6, slot 4). All other bits read 0, and writes to it have no effect.
- R9: Kicks on different slots run on separate counters. A later kick on one slot does not delay or advance the lock of another.
- R10: A kick write to a slot whose kick is already pending is ignored. It does not restart the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed word |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed word |
| mult_int_o | output | NUM_PLL×10 | Effective integer multipliers, slot s at bits 10s+9:10s |
| mult_frac_o | output | NUM_PLL×25 | Effective fractional factors, slot s at bits 25s+24:25s |

## Verification
If the active copy is wrong, the multiplier outputs show it one cycle after the kick edge, long before the lock flag returns. The bench checks those outputs right after the kick and again after lock. If a counter or lock flag is wrong, the kick bit and the status bit do not change together at exactly LOCK_CYCLES cycles. The bench samples both on the cycle before that edge and on the cycle after it. If a slot decodes the wrong status position or the wrong busy gate, it shows up as a wrong status word or as a write during a kick that changes the read-back value.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int NI_W    = 8;
  localparam int NF_W    = 25;
  localparam int MODE_W  = 3;
  localparam int FREQ_W  = 7;
  localparam int DEPTH_W = 7;
  localparam int MULT_W  = NI_W + 2;
  localparam int KICK_BIT = 31;
  localparam int FRAC_MODE_BIT = 2;  // bit 18 of word 0

  // status-word position of each slot's lock flag (PLL1,2,3,4,6)
  function automatic int lock_bit_pos(input int slot);
    case (slot)
      0:       return 8;
      1:       return 9;
      2:       return 11;
      3:       return 13;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int LOCK_CYCLES = 4500,
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        cnt_q  <= CNT_W'(LOCK_CYCLES);
        busy_q <= 1'b1;
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CNT_W'(1));

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(LOCK_CYCLES));
  p_idle_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && done_o) |=> (!busy_q || $past(start_i)));
endmodule

// File: rtl/pll_slot.sv
module pll_slot
  import pll_cfg_pkg::*;
#(
  parameter int LOCK_CYCLES = 4500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we0_i,
  input  logic              we1_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rd0_o,
  output logic [31:0]       rd1_o,
  output logic              locked_o,
  output logic [MULT_W-1:0] mult_int_o,
  output logic [NF_W-1:0]   mult_frac_o
);
  logic [NI_W-1:0]    stg_ni, act_ni;
  logic [NF_W-1:0]    stg_nf, act_nf;
  logic [MODE_W-1:0]  stg_mode, act_mode;
  logic [FREQ_W-1:0]  stg_freq;
  logic [DEPTH_W-1:0] stg_depth;
  logic               lock_q, busy, done, kick_acc;

  assign kick_acc = we0_i && wdata_i[KICK_BIT] && !busy;

  pll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) timer_i (
    .clk_i, .rst_ni, .start_i(kick_acc), .busy_o(busy), .done_o(done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_ni <= '0; stg_nf <= '0; stg_mode <= '0; stg_freq <= '0; stg_depth <= '0;
      act_ni <= '0; act_nf <= '0; act_mode <= '0;
      lock_q <= 1'b1;
    end else begin
      if (we0_i) begin
        stg_mode  <= wdata_i[18:16];
        stg_freq  <= wdata_i[14:8];
        stg_depth <= wdata_i[6:0];
        if (!busy) stg_ni <= wdata_i[27:20];
      end
      if (we1_i && !busy) stg_nf <= wdata_i[NF_W-1:0];
      if (kick_acc) begin
        // same-write fields take effect together with the kick
        act_ni   <= wdata_i[27:20];
        act_mode <= wdata_i[18:16];
        act_nf   <= stg_nf;
        lock_q   <= 1'b0;
      end else if (done) begin
        lock_q <= 1'b1;
      end
    end
  end

  assign rd0_o = {busy, 3'b0, stg_ni, 1'b0, stg_mode, 1'b0, stg_freq, 1'b0, stg_depth};
  assign rd1_o = {{(32-NF_W){1'b0}}, stg_nf};
  assign locked_o    = lock_q;
  assign mult_int_o  = ({2'b0, act_ni} + MULT_W'(1)) << 1;
  assign mult_frac_o = act_mode[FRAC_MODE_BIT] ? act_nf : '0;

  p_ni_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && we0_i) |=> stg_ni == $past(stg_ni));
  p_nf_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && we1_i) |=> stg_nf == $past(stg_nf));
  p_kick_unlock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_acc |=> (!lock_q && busy));
  p_lock_vs_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q == !busy);
  p_active_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !kick_acc |=> $stable(act_ni));
  p_no_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done) |=> busy);
endmodule

// File: rtl/pll_cfg_ctrl.sv
module pll_cfg_ctrl
  import pll_cfg_pkg::*;
#(
  parameter int NUM_PLL     = 5,
  parameter int LOCK_CYCLES = 4500,
  parameter int ADDR_W      = 4,
  localparam int STATUS_ADDR = 2 * NUM_PLL
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output logic [NUM_PLL*MULT_W-1:0] mult_int_o,
  output logic [NUM_PLL*NF_W-1:0]   mult_frac_o
);
  logic [31:0]        rd0 [NUM_PLL];
  logic [31:0]        rd1 [NUM_PLL];
  logic [NUM_PLL-1:0] locked;

  for (genvar s = 0; s < NUM_PLL; s++) begin : g_slot
    pll_slot #(.LOCK_CYCLES(LOCK_CYCLES)) slot_i (
      .clk_i,
      .rst_ni,
      .we0_i      (wr_en_i && addr_i == ADDR_W'(2*s)),
      .we1_i      (wr_en_i && addr_i == ADDR_W'(2*s+1)),
      .wdata_i,
      .rd0_o      (rd0[s]),
      .rd1_o      (rd1[s]),
      .locked_o   (locked[s]),
      .mult_int_o (mult_int_o[s*MULT_W +: MULT_W]),
      .mult_frac_o(mult_frac_o[s*NF_W +: NF_W])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(STATUS_ADDR)) begin
      for (int s = 0; s < NUM_PLL; s++) rdata_o[lock_bit_pos(s)] = locked[s];
    end else begin
      for (int s = 0; s < NUM_PLL; s++) begin
        if (addr_i == ADDR_W'(2*s))   rdata_o = rd0[s];
        if (addr_i == ADDR_W'(2*s+1)) rdata_o = rd1[s];
      end
    end
  end

  p_status_rsvd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(STATUS_ADDR)) |-> (rdata_o & ~32'h0000_AB00) == 32'h0);
endmodule

// File: tb/pll_cfg_ctrl_tb_top.sv
module pll_cfg_ctrl_tb_top;
  localparam int N = 5;
  localparam int L = 16;
  localparam logic [3:0] ST = 4'd10;
  localparam logic [31:0] ALL_LOCK = 32'h0000_AB00;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N*10-1:0] mint;
  logic [N*25-1:0] mfrac;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pll_cfg_ctrl #(.NUM_PLL(N), .LOCK_CYCLES(L)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .mult_int_o(mint), .mult_frac_o(mfrac)
  );

  localparam int NV = 6;
  localparam int          V_SLOT [NV] = '{0, 1, 2, 3, 4, 2};
  localparam logic [7:0]  V_NI   [NV] = '{8'd0, 8'd49, 8'd255, 8'd7, 8'd128, 8'd20};
  localparam logic        V_FRAC [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [24:0] V_NF   [NV] = '{25'h1FFFFFF, 25'h0800000, 25'h1FFFFFF,
                                          25'h0123456, 25'h0000001, 25'h1555555};
  localparam int LBIT [N] = '{8, 9, 11, 13, 15};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic logic [31:0] mi(input int s);
    return 32'(mint[s*10 +: 10]);
  endfunction
  function automatic logic [31:0] mf(input int s);
    return 32'(mfrac[s*25 +: 25]);
  endfunction

  initial begin
    logic [31:0] d;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    rd(ST, d); check("R1 status", d, ALL_LOCK);
    for (int s = 0; s < N; s++) begin
      rd(4'(2*s), d);   check("R1 word0", d, 32'h0);
      rd(4'(2*s+1), d); check("R1 word1", d, 32'h0);
      check("R1 mult_int", mi(s), 32'd2);
      check("R1 mult_frac", mf(s), 32'd0);
    end

    // R2 staged write, reserved bits dropped, outputs unchanged
    wr(4'd8, 32'h7008_8080 | (32'h7F << 20) | (32'd5 << 16) | (32'h55 << 8) | 32'h2A);
    rd(4'd8, d); check("R2 readback", d, (32'h7F << 20) | (32'd5 << 16) | (32'h55 << 8) | 32'h2A);
    check("R2 mult_int unchanged", mi(4), 32'd2);
    check("R2 mult_frac unchanged", mf(4), 32'd0);

    // vector table: R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      int s;
      logic [31:0] fexp;
      s = V_SLOT[v];
      wr(4'(2*s+1), 32'(V_NF[v]));
      wr(4'(2*s), 32'h8000_0000 | (32'(V_NI[v]) << 20) | (32'(V_FRAC[v]) << 18));
      rd(ST, d); check("R4 lock cleared", d, ALL_LOCK & ~(32'h1 << LBIT[s]));
      rd(4'(2*s), d); check("R4 kick pending", 32'(d[31]), 32'd1);
      check("R6 mult_int", mi(s), (32'(V_NI[v]) + 1) * 2);
      fexp = V_FRAC[v] ? 32'(V_NF[v]) : 32'd0;
      check("R7 mult_frac", mf(s), fexp);
      wait_n(L - 1);
      rd(ST, d); check("R5 not yet locked", d, ALL_LOCK & ~(32'h1 << LBIT[s]));
      rd(4'(2*s), d); check("R5 kick still set", 32'(d[31]), 32'd1);
      wait_n(1);
      rd(ST, d); check("R8 status after lock", d, ALL_LOCK);
      rd(4'(2*s), d); check("R5 kick cleared", 32'(d[31]), 32'd0);
    end

    // R3 writes to NI/NF ignored while pending
    wr(4'd5, 32'h0000_0000);
    wr(4'd4, 32'h8000_0000 | (32'h10 << 20));
    wr(4'd4, 32'h33 << 20);
    rd(4'd4, d); check("R3 NI held", 32'(d[27:20]), 32'h10);
    check("R3 kick bit", 32'(d[31]), 32'd1);
    wr(4'd5, 32'h0001234);
    rd(4'd5, d); check("R3 NF held", d, 32'h0);
    wait_n(L);
    check("R6 after R3", mi(2), 32'd34);

    // R10 repeated kick does not restart
    wr(4'd2, 32'h8000_0000 | (32'd3 << 20));
    wait_n(3);
    wr(4'd2, 32'h8000_0000 | (32'd9 << 20));
    wait_n(11);
    rd(ST, d); check("R10 still pending", 32'(d[9]), 32'd0);
    wait_n(1);
    rd(ST, d); check("R10 locks on original schedule", 32'(d[9]), 32'd1);
    check("R10 mult_int from first kick", mi(1), 32'd8);

    // R9 independent counters
    wr(4'd0, 32'h8000_0000 | (32'd1 << 20));
    wait_n(4);
    wr(4'd6, 32'h8000_0000 | (32'd2 << 20));
    wait_n(10);
    rd(ST, d); check("R9 slot0 pending", d, ALL_LOCK & ~32'h0000_2100);
    wait_n(1);
    rd(ST, d); check("R9 slot0 locked, slot3 pending", d, ALL_LOCK & ~32'h0000_2000);
    wait_n(4);
    rd(ST, d); check("R9 slot3 pending", 32'(d[13]), 32'd0);
    wait_n(1);
    rd(ST, d); check("R9 slot3 locked", d, ALL_LOCK);

    // R8 status write ignored
    wr(ST, 32'h0);
    rd(ST, d); check("R8 status write ignored", d, ALL_LOCK);
    for (int s = 0; s < N; s++) begin
      rd(4'(2*s), d); check("R8 no side effect on kick", 32'(d[31]), 32'd0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule